// File: doc/BRIEF.md
# Atomic memory operation unit

This block carries out the word-sized atomic read-modify-write instructions of a 32-bit RISC-V style core. The pipeline hands it an instruction word, the address taken from rs1 and the operand taken from rs2, and pulses `start`. The unit checks that the instruction belongs to the atomic group at word width and selects one of nine operations. It then reads the addressed word from memory, combines that word with the operand, and writes the result back to the same address. At the end it returns the old word for register write-back.

Memory is reached through one single-port request interface. A read or a write request is held until `mem_gnt`. Read data arrives later, marked by `mem_rvalid`. Load-reserved and store-conditional are recognised but not executed. Like any foreign or unlisted encoding, they end with an illegal flag and no memory traffic. A word address that is not aligned ends with a misaligned flag and no memory traffic.

Top module: `amo_unit`

## Requirements
- R1: An instruction is accepted only when bits [6:2] equal 01011 and bits [14:12] equal 010. Any other instruction ends with `err_illegal` high at `done` and makes no memory request.
- R2: The operation is chosen by bits [31:27]. Bits [26:25] (the ordering hints) never change the result, the stored value or the flags.
- R3: The funct5 codes 00010 (load-reserved) and 00011 (store-conditional), and every code not listed in R6 to R8, end with `err_illegal` and `rd_we` low. They make no memory request.
- R4: When rs1 bits [1:0] are not 00, a legal operation ends with `err_misaligned` and `rd_we` low and makes no memory request. Every issued request carries an address with bits [1:0] equal to 00.
- R5: Exactly one read is issued first, then exactly one write. Each request is held until `mem_gnt`. The write is not raised before `mem_rvalid` has delivered the read data, and its data and address stay stable while it waits.
- R6: The write goes to the rs1 address. Code 00000 stores old+rs2 modulo 2^32, 00001 stores rs2, 00100 stores old^rs2, 01100 stores old&rs2, and 01000 stores old|rs2.
- R7: Code 10000 stores the signed minimum of old and rs2, and code 10100 stores the signed maximum. Both compare the two values as two's complement.
- R8: Code 11000 stores the unsigned minimum and code 11100 stores the unsigned maximum.
- R9: `done` is high for exactly one cycle per accepted `start`. With it, `rd_data` holds the old memory word and `rd_idx` holds bits [11:7].
- R10: When bits [11:7] are zero, the memory update still happens and `rd_we` stays low.
- R11: After reset, `busy`, `done`, `rd_we`, both error flags and both request lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction; sampled only while idle |
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | Memory address |
| rs2_val | input | 32 | Source operand |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_we | output | 1 | Register write-back enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 32 | Old memory word |
| err_illegal | output | 1 | Illegal or unimplemented encoding, valid with done |
| err_misaligned | output | 1 | Unaligned address, valid with done |
| mem_rd_req | output | 1 | Read request |
| mem_wr_req | output | 1 | Write request |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions assume a memory that raises `mem_rvalid` only after it has granted a read, exactly once per read. They also assume that `start` is offered only while `busy` is low. The bench models such a memory. It grants after a chosen number of wait cycles and returns data one cycle after the grant. It only issues a new instruction after the previous `done`. Operands cover the signed and unsigned boundaries 0x80000000, 0x7FFFFFFF and 0xFFFFFFFF, and the bench varies the ordering bits and the grant latency.

// File: rtl/amo_pkg.sv
// Shared definitions for the atomic memory operation unit.
// Assumes a 32-bit instruction encoding with the R-type field layout.
package amo_pkg;
    localparam logic [4:0] OPC_AMO = 5'b01011;
    localparam logic [2:0] F3_WORD = 3'b010;

    typedef enum logic [3:0] {
        OP_ADD, OP_SWAP, OP_XOR, OP_AND, OP_OR,
        OP_MIN, OP_MAX, OP_MINU, OP_MAXU, OP_NONE
    } amo_op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_RDREQ, S_RDWAIT, S_WRREQ, S_DONE
    } amo_state_e;
endpackage

// File: rtl/amo_decode.sv
// Instruction decoder: says whether the word is an atomic word-width
// instruction and which operation its funct5 selects. Bits [26:25] are
// never looked at. Reserve/conditional codes and unlisted codes yield
// legal = 0. Purely combinational.
module amo_decode
    import amo_pkg::*;
(
    input  logic [31:0] instr,
    output logic        in_space,
    output logic        legal,
    output amo_op_e     op,
    output logic [4:0]  rd
);
    logic [4:0] funct5;

    // Field extraction and group match
    always_comb begin
        funct5   = instr[31:27];
        rd       = instr[11:7];
        in_space = (instr[6:2] == OPC_AMO) && (instr[14:12] == F3_WORD);
    end

    // funct5 to operation mapping
    always_comb begin
        unique case (funct5)
            5'b00000: op = OP_ADD;
            5'b00001: op = OP_SWAP;
            5'b00100: op = OP_XOR;
            5'b01100: op = OP_AND;
            5'b01000: op = OP_OR;
            5'b10000: op = OP_MIN;
            5'b10100: op = OP_MAX;
            5'b11000: op = OP_MINU;
            5'b11100: op = OP_MAXU;
            default:  op = OP_NONE;
        endcase
        legal = (op != OP_NONE);
    end
endmodule

// File: rtl/amo_alu.sv
// Combine stage: produces the value to store from the old memory word
// and the source operand. Assumes op is one of the executable operations.
module amo_alu
    import amo_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  amo_op_e             op,
    input  logic [DATA_W-1:0]   old_w,
    input  logic [DATA_W-1:0]   src_w,
    output logic [DATA_W-1:0]   result
);
    logic lt_signed;
    logic lt_unsigned;

    // Comparisons shared by the min/max variants
    always_comb begin
        lt_signed   = $signed(old_w) < $signed(src_w);
        lt_unsigned = old_w < src_w;
    end

    // Result selection
    always_comb begin
        unique case (op)
            OP_ADD:  result = old_w + src_w;
            OP_SWAP: result = src_w;
            OP_XOR:  result = old_w ^ src_w;
            OP_AND:  result = old_w & src_w;
            OP_OR:   result = old_w | src_w;
            OP_MIN:  result = lt_signed   ? old_w : src_w;
            OP_MAX:  result = lt_signed   ? src_w : old_w;
            OP_MINU: result = lt_unsigned ? old_w : src_w;
            OP_MAXU: result = lt_unsigned ? src_w : old_w;
            default: result = old_w;
        endcase
    end
endmodule

// File: rtl/amo_unit.sv
// Atomic memory operation unit top. Sequences read, combine and write on a
// single-port memory and returns the old word. Assumes start is offered
// only while idle and that mem_rvalid follows a granted read exactly once.
module amo_unit
    import amo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    input  logic [ADDR_W-1:0] rs1_val,
    input  logic [DATA_W-1:0] rs2_val,
    output logic              busy,
    output logic              done,
    output logic              rd_we,
    output logic [4:0]        rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_illegal,
    output logic              err_misaligned,
    output logic              mem_rd_req,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int ALIGN_BITS = $clog2(DATA_W / 8);

    amo_state_e         state;
    amo_op_e            op_q;
    logic [4:0]         rd_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  src_q;
    logic [DATA_W-1:0]  old_q;
    logic [DATA_W-1:0]  wdata_q;
    logic               ill_q;
    logic               mis_q;

    logic               dec_space;
    logic               dec_legal;
    amo_op_e            dec_op;
    logic [4:0]         dec_rd;
    logic               addr_bad;
    logic [DATA_W-1:0]  alu_res;

    amo_decode u_decode (
        .instr    (instr),
        .in_space (dec_space),
        .legal    (dec_legal),
        .op       (dec_op),
        .rd       (dec_rd)
    );

    amo_alu #(.DATA_W(DATA_W)) u_alu (
        .op     (op_q),
        .old_w  (mem_rdata),
        .src_w  (src_q),
        .result (alu_res)
    );

    // Alignment test on the incoming address
    always_comb addr_bad = (rs1_val[ALIGN_BITS-1:0] != '0);

    // Sequencer and operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            op_q    <= OP_NONE;
            rd_q    <= '0;
            addr_q  <= '0;
            src_q   <= '0;
            old_q   <= '0;
            wdata_q <= '0;
            ill_q   <= 1'b0;
            mis_q   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    op_q   <= dec_op;
                    rd_q   <= dec_rd;
                    addr_q <= rs1_val;
                    src_q  <= rs2_val;
                    ill_q  <= !(dec_space && dec_legal);
                    mis_q  <= dec_space && dec_legal && addr_bad;
                    if (dec_space && dec_legal && !addr_bad) state <= S_RDREQ;
                    else                                     state <= S_DONE;
                end
                S_RDREQ:  if (mem_gnt) state <= S_RDWAIT;
                S_RDWAIT: if (mem_rvalid) begin
                    old_q   <= mem_rdata;
                    wdata_q <= alu_res;
                    state   <= S_WRREQ;
                end
                S_WRREQ:  if (mem_gnt) state <= S_DONE;
                S_DONE:   state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    // Output decode from the state register
    always_comb begin
        busy           = (state != S_IDLE);
        done           = (state == S_DONE);
        mem_rd_req     = (state == S_RDREQ);
        mem_wr_req     = (state == S_WRREQ);
        mem_addr       = addr_q;
        mem_wdata      = wdata_q;
        rd_idx         = rd_q;
        rd_data        = old_q;
        err_illegal    = done && ill_q;
        err_misaligned = done && mis_q;
        rd_we          = done && !ill_q && !mis_q && (rd_q != 5'd0);
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_gnt) |=> mem_rd_req); // R5
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_gnt) |=> (mem_wr_req && $stable(mem_wdata) && $stable(mem_addr))); // R5
    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req)); // R5
    AST_ALIGNED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req || mem_wr_req) |-> (mem_addr[ALIGN_BITS-1:0] == '0)); // R4
    AST_ERR_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (err_illegal || err_misaligned) |-> !rd_we); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_MINMAX_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && (op_q inside {OP_MIN, OP_MAX, OP_MINU, OP_MAXU}))
        |-> (mem_wdata == old_q || mem_wdata == src_q)); // R7
    AST_ZERO_RD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> (rd_idx != 5'd0)); // R10
endmodule

// File: tb/amo_unit_tb.sv
// Bench: behavioural memory with adjustable grant latency and a reference
// calculation per instruction, checked every cycle and at each completion.
module amo_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs1_val = '0;
    logic [31:0] rs2_val = '0;
    logic        busy, done, rd_we, err_illegal, err_misaligned;
    logic [4:0]  rd_idx;
    logic [31:0] rd_data;
    logic        mem_rd_req, mem_wr_req;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int errors = 0;
    int checks = 0;
    logic [31:0] mem [logic [31:0]];

    always #5 clk = ~clk;

    amo_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .busy(busy), .done(done),
        .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data),
        .err_illegal(err_illegal), .err_misaligned(err_misaligned),
        .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_get(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] ref_calc(input logic [4:0] f5,
                                             input logic [31:0] o, input logic [31:0] b);
        case (f5)
            5'd0:  return o + b;
            5'd1:  return b;
            5'd4:  return o ^ b;
            5'd12: return o & b;
            5'd8:  return o | b;
            5'd16: return ($signed(o) < $signed(b)) ? o : b;
            5'd20: return ($signed(o) > $signed(b)) ? o : b;
            5'd24: return (o < b) ? o : b;
            5'd28: return (o > b) ? o : b;
            default: return o;
        endcase
    endfunction

    function automatic logic [31:0] mk(input logic [4:0] f5, input logic [1:0] ord,
                                       input logic [4:0] rd);
        return {f5, ord, 5'd2, 5'd1, 3'b010, rd, 7'b0101111};
    endfunction

    // Issue one instruction, serve memory and compare against the model
    task automatic do_op(input string req, input logic [31:0] ins,
                         input logic [31:0] a, input logic [31:0] b, input int dly);
        logic [4:0]  f5 = ins[31:27];
        logic        grp = (ins[6:2] == 5'b01011) && (ins[14:12] == 3'b010);
        logic        known = f5 inside {5'd0, 5'd1, 5'd4, 5'd12, 5'd8, 5'd16, 5'd20, 5'd24, 5'd28};
        logic        exp_ill = !(grp && known);
        logic        exp_mis = !exp_ill && (a[1:0] != 2'b00);
        logic        exp_run = !exp_ill && !exp_mis;
        logic [31:0] old = mem_get(a);
        logic [31:0] nv = ref_calc(f5, old, b);
        logic [31:0] got_data = '0;
        logic [31:0] raddr = '0, waddr = '0;
        logic        got_we = 1'b0, got_ill = 1'b0, got_mis = 1'b0, got_idx_ok = 1'b0;
        logic        rv_pending = 1'b0, seen_data = 1'b0, fin = 1'b0;
        int          rds = 0, wrs = 0, wc = 0, cyc = 0;
        @(negedge clk);
        start = 1'b1; instr = ins; rs1_val = a; rs2_val = b;
        @(negedge clk);
        start = 1'b0;
        while (!fin) begin
            mem_gnt = 1'b0; mem_rvalid = 1'b0;
            if (rv_pending) begin
                mem_rvalid = 1'b1; mem_rdata = mem_get(raddr);
                rv_pending = 1'b0; seen_data = 1'b1;
            end
            if (mem_rd_req && mem_wr_req) check("R5", "both requests", 32'd1, 32'd0);
            if (done) begin
                fin = 1'b1;
                got_data = rd_data; got_we = rd_we; got_ill = err_illegal;
                got_mis = err_misaligned; got_idx_ok = (rd_idx == ins[11:7]);
            end else if (mem_rd_req) begin
                if (wc >= dly) begin
                    mem_gnt = 1'b1; rds++; raddr = mem_addr; rv_pending = 1'b1; wc = 0;
                end else wc++;
            end else if (mem_wr_req) begin
                if (!seen_data) check("R5", "write before read data", 32'd1, 32'd0);
                if (wc >= dly) begin
                    mem_gnt = 1'b1; wrs++; waddr = mem_addr; mem[mem_addr] = mem_wdata; wc = 0;
                end else wc++;
            end
            cyc++;
            if (!fin && cyc > 200) begin
                check(req, "timeout", 32'd1, 32'd0);
                fin = 1'b1;
            end
            if (!fin) @(negedge clk);
        end
        check(req, "illegal flag", {31'd0, got_ill}, {31'd0, exp_ill});
        check(req, "misaligned flag", {31'd0, got_mis}, {31'd0, exp_mis});
        check(req, "rd_we", {31'd0, got_we}, {31'd0, exp_run && ins[11:7] != 5'd0});
        check(req, "reads", rds, exp_run ? 1 : 0);
        check(req, "writes", wrs, exp_run ? 1 : 0);
        if (exp_run) begin
            check(req, "rd_data old word", got_data, old);
            check(req, "rd_idx", {31'd0, got_idx_ok}, 32'd1);
            check(req, "read address", raddr, a);
            check(req, "write address", waddr, a);
            check(req, "stored value", mem_get(a), nv);
        end else begin
            check(req, "memory untouched", mem_get(a), old);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        mem[32'h100] = 32'hFFFF_FFFF;
        mem[32'h104] = 32'h8000_0000;
        mem[32'h108] = 32'h7FFF_FFFF;
        mem[32'h10C] = 32'h0000_0001;
        mem[32'h110] = 32'hF0F0_1234;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", "busy", {31'd0, busy}, 32'd0);
        check("R11", "done", {31'd0, done}, 32'd0);
        check("R11", "requests", {30'd0, mem_rd_req, mem_wr_req}, 32'd0);
        check("R11", "flags", {29'd0, rd_we, err_illegal, err_misaligned}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R6 arithmetic and bitwise, R9 old word returned
        do_op("R6", mk(5'd0, 2'b00, 5'd3), 32'h100, 32'h0000_0001, 0);   // wraps to 0
        do_op("R6", mk(5'd1, 2'b00, 5'd4), 32'h110, 32'hDEAD_BEEF, 1);
        do_op("R6", mk(5'd4, 2'b00, 5'd5), 32'h110, 32'hFFFF_0000, 2);
        do_op("R6", mk(5'd12, 2'b00, 5'd6), 32'h110, 32'h0F0F_F0F0, 0);
        do_op("R6", mk(5'd8, 2'b00, 5'd7), 32'h110, 32'h8000_0001, 3);
        do_op("R9", mk(5'd0, 2'b00, 5'd31), 32'h108, 32'h0000_0001, 0);  // 0x7FFFFFFF+1
        // R7 signed compare
        do_op("R7", mk(5'd16, 2'b00, 5'd8), 32'h10C, 32'h8000_0000, 1);
        do_op("R7", mk(5'd20, 2'b00, 5'd9), 32'h104, 32'h0000_0001, 0);
        do_op("R7", mk(5'd20, 2'b00, 5'd9), 32'h100, 32'h8000_0000, 2);
        mem[32'h120] = 32'hFFFF_FFFF;
        do_op("R7", mk(5'd16, 2'b00, 5'd1), 32'h120, 32'h0000_0000, 0);
        // R8 unsigned compare
        mem[32'h124] = 32'hFFFF_FFFF;
        do_op("R8", mk(5'd24, 2'b00, 5'd10), 32'h124, 32'h0000_0001, 1);
        mem[32'h128] = 32'h0000_0001;
        do_op("R8", mk(5'd28, 2'b00, 5'd11), 32'h128, 32'h8000_0000, 0);
        mem[32'h12C] = 32'h8000_0000;
        do_op("R8", mk(5'd24, 2'b00, 5'd12), 32'h12C, 32'h7FFF_FFFF, 2);
        // R2 ordering bits have no effect
        mem[32'h130] = 32'h0000_0010;
        do_op("R2", mk(5'd0, 2'b11, 5'd13), 32'h130, 32'h0000_0005, 0);
        do_op("R2", mk(5'd16, 2'b10, 5'd14), 32'h130, 32'hFFFF_FFFE, 1);
        do_op("R2", mk(5'd28, 2'b01, 5'd15), 32'h130, 32'h0000_0003, 0);
        // R3 reserve/conditional and unlisted codes
        do_op("R3", mk(5'd2, 2'b00, 5'd3), 32'h100, 32'h1, 0);
        do_op("R3", mk(5'd3, 2'b11, 5'd3), 32'h100, 32'h1, 0);
        do_op("R3", mk(5'd5, 2'b00, 5'd3), 32'h100, 32'h1, 0);
        // R1 wrong opcode or width
        do_op("R1", mk(5'd0, 2'b00, 5'd3) ^ 32'h0000_0004, 32'h100, 32'h1, 0);
        do_op("R1", mk(5'd0, 2'b00, 5'd3) ^ 32'h0000_1000, 32'h100, 32'h1, 0);
        // R4 misaligned addresses
        do_op("R4", mk(5'd1, 2'b00, 5'd3), 32'h101, 32'h55, 0);
        do_op("R4", mk(5'd0, 2'b00, 5'd3), 32'h106, 32'h55, 0);
        // R10 rd of zero still updates memory
        mem[32'h140] = 32'h1234_5678;
        do_op("R10", mk(5'd1, 2'b00, 5'd0), 32'h140, 32'hCAFE_F00D, 2);
        check("R10", "swap stored", mem_get(32'h140), 32'hCAFE_F00D);
        // R5 long grant latency
        do_op("R5", mk(5'd4, 2'b00, 5'd20), 32'h140, 32'h0000_FFFF, 6);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule